// File: doc/BRIEF.md
# Two-Level Page Entry Translation Cache

This block is a set-associative cache of page-translation entries for a 32-bit virtual address space with 4 KB pages. A single array holds two kinds of entry. Table-level entries map one virtual page to a physical page. Directory-level entries cover the 4 MB region named by the top ten address bits. A one-bit level flag on every entry keeps the two kinds apart.

A lookup is combinational. The address is split into a table key and a directory key, and both keys are compared in the same cycle. A table hit returns a full physical address. If only the directory level is cached, the block returns the cached directory word, so that a page walker can skip its first memory read.

Entries are installed through a fill port and written on the clock edge. Two invalidation controls are provided. The task-switch flush keeps entries marked global. The full wipe clears everything. Within a set, replacement takes an invalid way first and otherwise uses a pseudo-LRU tree.

Top module: `xlat_tlb`

## Requirements
- R1: With `look_en` high and a valid table-level entry cached for `look_va[31:12]`, `look_hit` is 1, `look_dir` is 0, `look_pa` equals the entry word bits [31:12] followed by `look_va[11:0]`, and `look_word` is the entry word, all in the same cycle.
- R2: If no table-level entry matches but a directory-level entry keyed by `look_va[31:22]` does, `look_hit` is 1, `look_dir` is 1, `look_word` is the directory word and `look_pa` is 0. A table-level match takes priority over a directory-level match.
- R3: A hit needs all three of the following in the indexed set: a valid bit, an equal tag, and an equal level flag (1 = directory, 0 = table). A table-level entry never answers a directory key, and a directory-level entry never answers a table key, even when the key bits are the same. On a miss, `look_hit`, `look_pa` and `look_word` are 0.
- R4: The array has 16 sets of 4 ways. A 20-bit key selects its set with its low 4 bits and is tagged by its high 16 bits. The directory key is `look_va[31:22]` zero-extended to 20 bits. Four keys that share a set index can all be resident at once.
- R5: A fill is written on the rising clock edge while `fill_en` is high. A lookup of the same key in the cycle that presents the fill misses, and the same lookup hits in the next cycle.
- R6: A fill goes to the lowest-numbered invalid way of its set. When the set is full, the victim comes from a 3-bit tree pseudo-LRU that is updated on every lookup hit and every fill. After ways 0 to 3 are filled in that order and way 0 is then hit, the next fill evicts way 2.
- R7: A fill whose key and level match a valid entry rewrites that entry in place. No duplicate is created, and no other way of the set is displaced.
- R8: A `task_flush` pulse invalidates every entry whose word bit 8 is 0 and keeps the entries whose bit 8 is 1. The change is visible from the next cycle.
- R9: A `wipe_all` pulse invalidates every entry, global ones included, within one cycle.
- R10: A fill that is presented in the same cycle as `task_flush` or `wipe_all` is dropped.
- R11: With `look_en` low, `look_hit`, `look_dir`, `look_pa` and `look_word` are all 0, whatever is cached.
- R12: After reset every entry is invalid, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| look_en | input | 1 | A lookup is being made this cycle |
| look_va | input | 32 | Virtual address to translate |
| look_hit | output | 1 | Some entry answered the lookup |
| look_dir | output | 1 | The answer is a directory-level entry |
| look_pa | output | 32 | Physical address on a table-level hit, 0 otherwise |
| look_word | output | 32 | Cached entry word that answered |
| fill_en | input | 1 | Install an entry at the next edge |
| fill_dir | input | 1 | Level of the entry being installed (1 = directory) |
| fill_va | input | 32 | Virtual address whose key the entry is installed under |
| fill_word | input | 32 | Entry word to install |
| task_flush | input | 1 | Drop all non-global entries |
| wipe_all | input | 1 | Drop all entries |

## Verification
The bench builds the block with its default parameters: 16 sets, 4 ways, a 10-bit directory key and the global flag at bit 8. With four ways, the tree pseudo-LRU variant is selected, so a directed sequence of fills and hits can show exactly which way is evicted. Because the table key and the zero-extended directory key share one key space, a directory entry and a table entry can be made to fall in the same set with the same tag. This makes the level-flag check observable. Both invalidation controls are driven against a mix of global and non-global entries, and each is also driven together with a fill, so that the dropping of that fill can be seen.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic {
      LVL_TABLE = 1'b0,
      LVL_DIR   = 1'b1
   } xlat_level_e;
endpackage

// File: rtl/xlat_way_cmp.sv
module xlat_way_cmp #(
   parameter int WAYS  = 4,
   parameter int TAG_W = 16,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0]            vld,
   input  logic [WAYS-1:0]            lvl,
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [TAG_W-1:0]           q_tag,
   input  logic                       q_lvl,
   output logic                       hit,
   output logic [WAY_W-1:0]           way,
   output logic [WAYS-1:0]            match
);
   always_comb begin
      for (int i = 0; i < WAYS; i++)
         match[i] = vld[i] && (lvl[i] == q_lvl) && (tags[i] == q_tag);
   end

   // the lowest-numbered way wins when several match
   always_comb begin
      way = '0;
      for (int i = WAYS - 1; i >= 0; i--)
         if (match[i]) way = WAY_W'(i);
   end

   assign hit = |match;
endmodule

// File: rtl/xlat_plru.sv
module xlat_plru #(
   parameter int SETS  = 16,
   parameter int WAYS  = 4,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way,
   input  logic [IDX_W-1:0] query_set,
   output logic [WAY_W-1:0] victim
);
   generate
      if (WAYS == 4) begin : g_tree
         // bit0: 0 -> victim in ways 0/1, 1 -> ways 2/3
         // bit1: victim inside 0/1, bit2: victim inside 2/3
         logic [SETS-1:0][2:0] st_q;

         function automatic logic [1:0] pick(input logic [2:0] s);
            return s[0] ? {1'b1, s[2]} : {1'b0, s[1]};
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else if (touch_en) begin
               st_q[touch_set][0] <= ~touch_way[1];
               if (touch_way[1]) st_q[touch_set][2] <= ~touch_way[0];
               else              st_q[touch_set][1] <= ~touch_way[0];
            end
         end

         assign victim = pick(st_q[query_set]);

         // R6
         touch_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
            touch_en |=> pick(st_q[$past(touch_set)]) != $past(touch_way));
      end else begin : g_pair
         logic [SETS-1:0] st_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else if (touch_en) st_q[touch_set] <= ~touch_way[0];
         end

         assign victim = st_q[query_set];

         // R6
         touch_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
            touch_en |=> st_q[$past(touch_set)] != $past(touch_way[0]));
      end
   endgenerate
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
   import xlat_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int OFF_W      = 12,
   parameter int SETS       = 16,
   parameter int WAYS       = 4,
   parameter int ENTRY_W    = 32,
   parameter int DIR_KEY_W  = 10,
   parameter int GLOBAL_BIT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               look_en,
   input  logic [VA_W-1:0]    look_va,
   output logic               look_hit,
   output logic               look_dir,
   output logic [VA_W-1:0]    look_pa,
   output logic [ENTRY_W-1:0] look_word,
   input  logic               fill_en,
   input  logic               fill_dir,
   input  logic [VA_W-1:0]    fill_va,
   input  logic [ENTRY_W-1:0] fill_word,
   input  logic               task_flush,
   input  logic               wipe_all
);
   localparam int VPN_W = VA_W - OFF_W;
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = VPN_W - IDX_W;
   localparam int WAY_W = $clog2(WAYS);

   initial begin
      assert (WAYS == 2 || WAYS == 4) else $error("WAYS must be 2 or 4");
      assert (SETS >= 2 && SETS == (1 << IDX_W)) else $error("SETS must be a power of two");
      assert (ENTRY_W >= VPN_W) else $error("entry too narrow for a page number");
      assert (GLOBAL_BIT < ENTRY_W) else $error("global bit outside the entry");
      assert (DIR_KEY_W <= VPN_W) else $error("directory key too wide");
   end

   logic [SETS-1:0][WAYS-1:0]              v_q, d_q;
   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   t_q;
   logic [SETS-1:0][WAYS-1:0][ENTRY_W-1:0] w_q;

   function automatic logic [VPN_W-1:0] key_of(input logic [VA_W-1:0] va, input logic dir);
      return dir ? VPN_W'(va[VA_W-1 -: DIR_KEY_W]) : va[VA_W-1:OFF_W];
   endfunction

   logic [VPN_W-1:0] t_key, d_key, f_key;
   logic [IDX_W-1:0] t_idx, d_idx, f_idx;
   logic [TAG_W-1:0] t_tag, d_tag, f_tag;

   assign t_key = key_of(look_va, 1'b0);
   assign d_key = key_of(look_va, 1'b1);
   assign f_key = key_of(fill_va, fill_dir);
   assign t_idx = t_key[IDX_W-1:0];
   assign d_idx = d_key[IDX_W-1:0];
   assign f_idx = f_key[IDX_W-1:0];
   assign t_tag = t_key[VPN_W-1:IDX_W];
   assign d_tag = d_key[VPN_W-1:IDX_W];
   assign f_tag = f_key[VPN_W-1:IDX_W];

   logic             t_hit, d_hit, f_hit;
   logic [WAY_W-1:0] t_way, d_way, f_way;
   logic [WAYS-1:0]  t_match, d_match, f_match;

   xlat_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_tcmp (
      .vld(v_q[t_idx]), .lvl(d_q[t_idx]), .tags(t_q[t_idx]), .q_tag(t_tag),
      .q_lvl(LVL_TABLE), .hit(t_hit), .way(t_way), .match(t_match));

   xlat_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_dcmp (
      .vld(v_q[d_idx]), .lvl(d_q[d_idx]), .tags(t_q[d_idx]), .q_tag(d_tag),
      .q_lvl(LVL_DIR), .hit(d_hit), .way(d_way), .match(d_match));

   xlat_way_cmp #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fcmp (
      .vld(v_q[f_idx]), .lvl(d_q[f_idx]), .tags(t_q[f_idx]), .q_tag(f_tag),
      .q_lvl(fill_dir), .hit(f_hit), .way(f_way), .match(f_match));

   // lookup results
   assign look_hit = look_en & (t_hit | d_hit);
   assign look_dir = look_en & ~t_hit & d_hit;
   assign look_pa  = (look_en & t_hit)
                     ? {w_q[t_idx][t_way][ENTRY_W-1 -: VPN_W], look_va[OFF_W-1:0]} : '0;
   always_comb begin
      if (look_en && t_hit)      look_word = w_q[t_idx][t_way];
      else if (look_en && d_hit) look_word = w_q[d_idx][d_way];
      else                       look_word = '0;
   end

   // fill way choice: same key, then lowest free way, then tree victim
   logic             free_any;
   logic [WAY_W-1:0] free_way, vic_way, fill_way;
   logic             fill_go;

   always_comb begin
      free_any = 1'b0;
      free_way = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (!v_q[f_idx][i]) begin
            free_any = 1'b1;
            free_way = WAY_W'(i);
         end
      end
   end

   assign fill_go  = fill_en & ~task_flush & ~wipe_all;
   assign fill_way = f_hit ? f_way : (free_any ? free_way : vic_way);

   logic             touch_en;
   logic [IDX_W-1:0] touch_set;
   logic [WAY_W-1:0] touch_way;

   assign touch_en  = fill_go | look_hit;
   assign touch_set = fill_go ? f_idx : (t_hit ? t_idx : d_idx);
   assign touch_way = fill_go ? fill_way : (t_hit ? t_way : d_way);

   xlat_plru #(.SETS(SETS), .WAYS(WAYS)) u_plru (
      .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_set(touch_set),
      .touch_way(touch_way), .query_set(f_idx), .victim(vic_way));

   // storage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= '0;
      else if (wipe_all) v_q <= '0;
      else if (task_flush) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               v_q[s][w] <= v_q[s][w] & w_q[s][w][GLOBAL_BIT];
      end else if (fill_go) v_q[f_idx][fill_way] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (fill_go) begin
         d_q[f_idx][fill_way] <= fill_dir;
         t_q[f_idx][fill_way] <= f_tag;
         w_q[f_idx][fill_way] <= fill_word;
      end
   end

   // checks
   logic live_local;
   always_comb begin
      live_local = 1'b0;
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++)
            if (v_q[s][w] && !w_q[s][w][GLOBAL_BIT]) live_local = 1'b1;
   end

   // R9
   wipe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wipe_all |=> (v_q == '0));

   // R8
   flush_keeps_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
      task_flush |=> !live_local);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !look_en |-> (!look_hit && !look_dir && look_pa == '0 && look_word == '0));

   // R7
   unique_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      look_en |-> ($onehot0(t_match) && $onehot0(d_match)));

   // R5
   fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_go |=> v_q[$past(f_idx)][$past(fill_way)]);

   // R10
   fill_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && wipe_all) |=> (v_q == '0));
endmodule

// File: tb/xlat_tlb_tb.sv
module xlat_tlb_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        look_en = 1'b0;
   logic [31:0] look_va = '0;
   logic        look_hit, look_dir;
   logic [31:0] look_pa, look_word;
   logic        fill_en = 1'b0;
   logic        fill_dir = 1'b0;
   logic [31:0] fill_va = '0;
   logic [31:0] fill_word = '0;
   logic        task_flush = 1'b0;
   logic        wipe_all = 1'b0;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   xlat_tlb u_dut (
      .clk(clk), .rst_n(rst_n), .look_en(look_en), .look_va(look_va),
      .look_hit(look_hit), .look_dir(look_dir), .look_pa(look_pa),
      .look_word(look_word), .fill_en(fill_en), .fill_dir(fill_dir),
      .fill_va(fill_va), .fill_word(fill_word), .task_flush(task_flush),
      .wipe_all(wipe_all));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic do_fill(input logic dir, input logic [31:0] va, input logic [31:0] word);
      @(negedge clk);
      fill_en = 1'b1; fill_dir = dir; fill_va = va; fill_word = word;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   // lookup held across one edge, results sampled before it
   logic        r_hit, r_dir;
   logic [31:0] r_pa, r_word;
   task automatic do_look(input logic [31:0] va);
      @(negedge clk);
      look_en = 1'b1; look_va = va;
      #2;
      r_hit = look_hit; r_dir = look_dir; r_pa = look_pa; r_word = look_word;
      @(negedge clk);
      look_en = 1'b0;
   endtask

   task automatic pulse_wipe();
      @(negedge clk);
      wipe_all = 1'b1;
      @(negedge clk);
      wipe_all = 1'b0;
   endtask

   task automatic t_reset();
      do_look(32'h1234_5678);
      chk("R12 hit after reset", {31'd0, r_hit}, 32'd0);
      chk("R12 pa after reset", r_pa, 32'd0);
      chk("R3 word on miss", r_word, 32'd0);
   endtask

   task automatic t_table_hit();
      pulse_wipe();
      do_fill(1'b0, 32'h1234_5000, 32'hABCD_E003);
      do_look(32'h1234_5678);
      chk("R1 hit", {31'd0, r_hit}, 32'd1);
      chk("R1 level", {31'd0, r_dir}, 32'd0);
      chk("R1 pa", r_pa, 32'hABCD_E678);
      chk("R1 word", r_word, 32'hABCD_E003);
      // R4: four tags in set 5 together
      do_fill(1'b0, 32'h0002_5000, 32'h2000_0000);
      do_fill(1'b0, 32'h0003_5000, 32'h3000_0000);
      do_fill(1'b0, 32'h0004_5000, 32'h4000_0000);
      do_look(32'h1234_5001);
      chk("R4 first of four", r_pa, 32'hABCD_E001);
      do_look(32'h0002_5010);
      chk("R4 second of four", r_pa, 32'h2000_0010);
      do_look(32'h0004_5abc);
      chk("R4 fourth of four", r_pa, 32'h4000_0ABC);
   endtask

   task automatic t_dir_hit();
      pulse_wipe();
      do_fill(1'b1, 32'h1234_5678, 32'h00AB_C001);
      do_look(32'h1234_5678);
      chk("R2 dir hit", {30'd0, r_hit, r_dir}, 32'd3);
      chk("R2 dir word", r_word, 32'h00AB_C001);
      chk("R2 dir pa zero", r_pa, 32'd0);
      do_look(32'h1239_9000);
      chk("R2 same region", r_word, 32'h00AB_C001);
      do_fill(1'b0, 32'h1234_5000, 32'h5555_5007);
      do_look(32'h1234_5678);
      chk("R2 table priority level", {31'd0, r_dir}, 32'd0);
      chk("R2 table priority pa", r_pa, 32'h5555_5678);
   endtask

   task automatic t_flag_tag();
      pulse_wipe();
      // directory key 0x00048: same set and tag as table page 0x00048
      do_fill(1'b1, 32'h1234_5678, 32'h00AB_C001);
      do_look(32'h0004_8123);
      chk("R3 level flag separates", {31'd0, r_hit}, 32'd0);
      do_fill(1'b0, 32'h0001_5000, 32'h7777_7000);
      do_look(32'h0005_5000);
      chk("R3 tag mismatch", {31'd0, r_hit}, 32'd0);
      chk("R3 pa on miss", r_pa, 32'd0);
   endtask

   task automatic t_fill_timing();
      pulse_wipe();
      @(negedge clk);
      fill_en = 1'b1; fill_dir = 1'b0; fill_va = 32'h00C0_3000; fill_word = 32'h9999_9000;
      look_en = 1'b1; look_va = 32'h00C0_3004;
      #2;
      chk("R5 same cycle miss", {31'd0, look_hit}, 32'd0);
      @(negedge clk);
      fill_en = 1'b0;
      #2;
      chk("R5 next cycle hit", {31'd0, look_hit}, 32'd1);
      chk("R5 next cycle pa", look_pa, 32'h9999_9004);
      @(negedge clk);
      look_en = 1'b0;
   endtask

   task automatic t_replace();
      pulse_wipe();
      do_fill(1'b0, 32'h0001_5000, 32'hA000_0000);
      do_fill(1'b0, 32'h0002_5000, 32'hB000_0000);
      do_fill(1'b0, 32'h0003_5000, 32'hC000_0000);
      do_fill(1'b0, 32'h0004_5000, 32'hD000_0000);
      do_look(32'h0001_5000);
      chk("R6 touch way0", {31'd0, r_hit}, 32'd1);
      do_fill(1'b0, 32'h0005_5000, 32'hE000_0000);
      do_look(32'h0003_5000);
      chk("R6 way2 evicted", {31'd0, r_hit}, 32'd0);
      do_look(32'h0001_5000);
      chk("R6 way0 kept", r_pa, 32'hA000_0000);
      do_look(32'h0002_5000);
      chk("R6 way1 kept", r_pa, 32'hB000_0000);
      do_look(32'h0004_5000);
      chk("R6 way3 kept", r_pa, 32'hD000_0000);
      do_look(32'h0005_5000);
      chk("R6 new entry", r_pa, 32'hE000_0000);
   endtask

   task automatic t_overwrite();
      pulse_wipe();
      do_fill(1'b0, 32'h0001_7000, 32'h1111_1000);
      do_fill(1'b0, 32'h0001_7000, 32'h2222_2000);
      do_fill(1'b0, 32'h0002_7000, 32'h3333_3000);
      do_fill(1'b0, 32'h0003_7000, 32'h4444_4000);
      do_fill(1'b0, 32'h0004_7000, 32'h5555_5000);
      do_look(32'h0001_7000);
      chk("R7 rewritten value", r_pa, 32'h2222_2000);
      do_look(32'h0002_7000);
      chk("R7 neighbour b", r_pa, 32'h3333_3000);
      do_look(32'h0003_7000);
      chk("R7 neighbour c", r_pa, 32'h4444_4000);
      do_look(32'h0004_7000);
      chk("R7 neighbour d", r_pa, 32'h5555_5000);
   endtask

   task automatic t_flush_wipe();
      pulse_wipe();
      do_fill(1'b0, 32'h0001_5000, 32'h1111_1100);
      do_fill(1'b0, 32'h0002_5000, 32'h2222_2000);
      @(negedge clk);
      task_flush = 1'b1;
      @(negedge clk);
      task_flush = 1'b0;
      do_look(32'h0001_5000);
      chk("R8 global kept", r_pa, 32'h1111_1000);
      do_look(32'h0002_5000);
      chk("R8 local dropped", {31'd0, r_hit}, 32'd0);
      pulse_wipe();
      do_look(32'h0001_5000);
      chk("R9 global wiped", {31'd0, r_hit}, 32'd0);
   endtask

   task automatic t_fill_blocked();
      pulse_wipe();
      @(negedge clk);
      fill_en = 1'b1; fill_dir = 1'b0; fill_va = 32'h0008_1000; fill_word = 32'h8888_8100;
      task_flush = 1'b1;
      @(negedge clk);
      fill_en = 1'b0; task_flush = 1'b0;
      do_look(32'h0008_1000);
      chk("R10 fill with flush dropped", {31'd0, r_hit}, 32'd0);
      @(negedge clk);
      fill_en = 1'b1; fill_va = 32'h0009_1000;
      wipe_all = 1'b1;
      @(negedge clk);
      fill_en = 1'b0; wipe_all = 1'b0;
      do_look(32'h0009_1000);
      chk("R10 fill with wipe dropped", {31'd0, r_hit}, 32'd0);
   endtask

   task automatic t_idle();
      pulse_wipe();
      do_fill(1'b0, 32'h0006_2000, 32'h6666_6000);
      @(negedge clk);
      look_en = 1'b0; look_va = 32'h0006_2000;
      #2;
      chk("R11 idle hit", {31'd0, look_hit}, 32'd0);
      chk("R11 idle pa", look_pa, 32'd0);
      chk("R11 idle word", look_word, 32'd0);
   endtask

   initial begin
      #(200000 * 8);
      total++; bad++;
      $display("FAIL watchdog got=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_table_hit();
      t_dir_hit();
      t_flag_tag();
      t_fill_timing();
      t_replace();
      t_overwrite();
      t_flush_wipe();
      t_fill_blocked();
      t_idle();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule